// File: doc/BRIEF.md
# At-Speed Burst Test Wrapper

This wrapper sits between a slow external tester and a pipelined circuit under test (CUT). The tester shifts a set of test vectors into an on-chip pattern register one bit at a time, using a slow clock-enable. A single trigger flag then starts a burst. During the burst every stored vector is driven into the CUT on consecutive cycles of the fast clock. The CUT responses are captured into a result register after a programmable pipeline latency.

When the burst is over, the tester shifts the results back out one bit per slow-enable pulse. Loading, the burst and readout always happen in that order. The tester therefore only handles slow serial signals, while the CUT is exercised back to back at full rate.

The CUT data width, the number of vectors and the CUT latency are parameters. A latency of zero selects a variant with no drain phase, for a purely combinational CUT.

Top module: `atspeed_wrap`

## Requirements
- R1: After reset, busy, done, scan_out and cut_din are all 0.
- R2: In idle or while loading, each cycle with slow_en high shifts scan_in into the pattern register. A load is complete after NPAT*DW such pulses. The first DW bits sent form vector 0, most significant bit first, then vector 1, and so on.
- R3: trigger starts a burst only in idle after a complete load. It is ignored before a load completes, while busy, and after a burst that had no new load.
- R4: Vector k appears on cut_din in the (k+1)-th cycle after the clock edge that samples trigger, for k = 0..NPAT-1, one per cycle with no gaps. Outside the burst, cut_din is 0.
- R5: The result slot for vector k holds the value of cut_dout exactly LATENCY cycles after vector k was on cut_din.
- R6: Once the burst and drain are over, each slow_en pulse shifts out one result bit. scan_out changes only on the cycle after a slow_en pulse. Result 0 comes out first, then result 1, and so on, each most significant bit first.
- R7: done is a one-cycle pulse that appears together with the last result bit. busy is low in that same cycle, and the wrapper is back in idle.
- R8: busy is high from the cycle after the accepted trigger until done. slow_en pulses during the burst or drain change neither the applied vectors nor the captured results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | Slow shift enable, one bit per high cycle |
| scan_in | input | 1 | Serial vector input |
| trigger | input | 1 | Burst start flag |
| cut_dout | input | DW | Response from the CUT |
| scan_out | output | 1 | Serial result output |
| busy | output | 1 | Burst, drain or readout in progress |
| done | output | 1 | One-cycle pulse with the last result bit |
| cut_din | output | DW | Vector driven into the CUT |

## Verification
A sequencer stuck in the wrong state shows on busy and cut_din within one cycle of the trigger edge. A capture window that is off by one cycle shows up only at readout, as a result word holding the neighbouring vector or a stale CUT value. A wrong shift order or a wrong bit count shows as swapped bytes, or as done arriving at the wrong pulse, during the NPAT*DW-pulse readout. Each of these is seen within one load, burst and readout sequence.

// File: rtl/atw_pkg.sv
package atw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOAD   = 3'd1,
      ST_RUN    = 3'd2,
      ST_DRAIN  = 3'd3,
      ST_UNLOAD = 3'd4
   } atw_state_e;
endpackage

// File: rtl/atw_seq.sv
module atw_seq
   import atw_pkg::*;
#(
   parameter int NPAT    = 4,
   parameter int DW      = 8,
   parameter int LATENCY = 3,
   localparam int TOT    = NPAT * DW,
   localparam int IW     = $clog2(NPAT),
   localparam int BCW    = $clog2(TOT + 1),
   localparam int CCW    = $clog2(NPAT + LATENCY + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_en,
   input  logic          trigger,
   output logic          load_sh,
   output logic          unl_sh,
   output logic          run_on,
   output logic [IW-1:0] run_idx,
   output logic          cap_en,
   output logic [IW-1:0] cap_idx,
   output logic          busy,
   output logic          done
);
   atw_state_e     state_q;
   logic [BCW-1:0] bcnt_q;
   logic [CCW-1:0] ccnt_q;
   logic           loaded_q;
   logic           done_q;
   logic           start;

   assign start = (state_q == ST_IDLE) && trigger && loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bcnt_q   <= '0;
         ccnt_q   <= '0;
         loaded_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q  <= ST_RUN;
                  ccnt_q   <= '0;
                  loaded_q <= 1'b0;
               end else if (slow_en) begin
                  state_q  <= ST_LOAD;
                  bcnt_q   <= BCW'(1);
                  loaded_q <= 1'b0;
               end
            end
            ST_LOAD: begin
               if (slow_en) begin
                  if (bcnt_q == BCW'(TOT - 1)) begin
                     state_q  <= ST_IDLE;
                     loaded_q <= 1'b1;
                  end else begin
                     bcnt_q <= bcnt_q + 1'b1;
                  end
               end
            end
            ST_RUN: begin
               ccnt_q <= ccnt_q + 1'b1;
               if (ccnt_q == CCW'(NPAT - 1)) begin
                  state_q <= (LATENCY == 0) ? ST_UNLOAD : ST_DRAIN;
                  bcnt_q  <= '0;
               end
            end
            ST_DRAIN: begin
               ccnt_q <= ccnt_q + 1'b1;
               if (ccnt_q == CCW'(NPAT + LATENCY - 1)) begin
                  state_q <= ST_UNLOAD;
                  bcnt_q  <= '0;
               end
            end
            ST_UNLOAD: begin
               if (slow_en) begin
                  if (bcnt_q == BCW'(TOT - 1)) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     bcnt_q <= bcnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign load_sh = slow_en && (((state_q == ST_IDLE) && !start) || (state_q == ST_LOAD));
   assign unl_sh  = slow_en && (state_q == ST_UNLOAD);
   assign run_on  = (state_q == ST_RUN);
   assign run_idx = ccnt_q[IW-1:0];
   assign busy    = (state_q == ST_RUN) || (state_q == ST_DRAIN) || (state_q == ST_UNLOAD);
   assign done    = done_q;

   generate
      if (LATENCY == 0) begin : g_comb_cut
         assign cap_en  = run_on;
         assign cap_idx = ccnt_q[IW-1:0];
      end else begin : g_pipe_cut
         logic [CCW-1:0] rel;
         assign rel     = ccnt_q - CCW'(LATENCY);
         assign cap_en  = ((state_q == ST_RUN) || (state_q == ST_DRAIN))
                          && (ccnt_q >= CCW'(LATENCY));
         assign cap_idx = rel[IW-1:0];
      end
   endgenerate
endmodule

// File: rtl/atw_pat_store.sv
module atw_pat_store #(
   parameter int NPAT = 4,
   parameter int DW   = 8,
   localparam int TOT = NPAT * DW,
   localparam int IW  = $clog2(NPAT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_sh,
   input  logic          scan_in,
   input  logic          run_on,
   input  logic [IW-1:0] run_idx,
   output logic [DW-1:0] cut_din
);
   logic [TOT-1:0] pat_q;
   logic [DW-1:0]  slot [NPAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pat_q <= '0;
      else if (load_sh) pat_q <= {pat_q[TOT-2:0], scan_in};
   end

   generate
      for (genvar s = 0; s < NPAT; s++) begin : g_slot
         assign slot[s] = pat_q[TOT-1-s*DW -: DW];
      end
   endgenerate

   assign cut_din = run_on ? slot[run_idx] : '0;
endmodule

// File: rtl/atw_res_store.sv
module atw_res_store #(
   parameter int NPAT = 4,
   parameter int DW   = 8,
   localparam int TOT = NPAT * DW,
   localparam int IW  = $clog2(NPAT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic [IW-1:0] cap_idx,
   input  logic [DW-1:0] cut_dout,
   input  logic          unl_sh,
   output logic          scan_out
);
   logic [TOT-1:0] res_q;
   logic           sout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         sout_q <= 1'b0;
      end else if (unl_sh) begin
         sout_q <= res_q[TOT-1];
         res_q  <= {res_q[TOT-2:0], 1'b0};
      end else if (cap_en) begin
         for (int s = 0; s < NPAT; s++) begin
            if (cap_idx == IW'(s)) res_q[TOT-1-s*DW -: DW] <= cut_dout;
         end
      end
   end

   assign scan_out = sout_q;
endmodule

// File: rtl/atspeed_wrap.sv
module atspeed_wrap #(
   parameter int NPAT    = 4,
   parameter int DW      = 8,
   parameter int LATENCY = 3,
   localparam int IW     = $clog2(NPAT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_en,
   input  logic          scan_in,
   input  logic          trigger,
   input  logic [DW-1:0] cut_dout,
   output logic          scan_out,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] cut_din
);
   generate
      if (NPAT < 2) begin : g_bad_npat
         $error("atspeed_wrap: NPAT must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("atspeed_wrap: DW must be at least 1");
      end
      if (LATENCY < 0) begin : g_bad_lat
         $error("atspeed_wrap: LATENCY must not be negative");
      end
   endgenerate

   logic          load_sh, unl_sh, run_on, cap_en;
   logic [IW-1:0] run_idx, cap_idx;

   atw_seq #(.NPAT(NPAT), .DW(DW), .LATENCY(LATENCY)) u_seq (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .trigger(trigger),
      .load_sh(load_sh), .unl_sh(unl_sh), .run_on(run_on), .run_idx(run_idx),
      .cap_en(cap_en), .cap_idx(cap_idx), .busy(busy), .done(done)
   );

   atw_pat_store #(.NPAT(NPAT), .DW(DW)) u_pat (
      .clk(clk), .rst_n(rst_n), .load_sh(load_sh), .scan_in(scan_in),
      .run_on(run_on), .run_idx(run_idx), .cut_din(cut_din)
   );

   atw_res_store #(.NPAT(NPAT), .DW(DW)) u_res (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
      .cut_dout(cut_dout), .unl_sh(unl_sh), .scan_out(scan_out)
   );
endmodule

// File: rtl/atw_chk.sv
module atw_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          slow_en,
   input logic          trigger,
   input logic          scan_out,
   input logic          busy,
   input logic          done,
   input logic [DW-1:0] cut_din
);
   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!busy && !done && !scan_out && cut_din == '0); // R1
      end
   end

   AST_BUSY_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(trigger)); // R3

   AST_DIN_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cut_din == '0)); // R4

   AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(slow_en) |-> $stable(scan_out)); // R6

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(slow_en) && $past(busy))); // R7

   AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8
endmodule

bind atspeed_wrap atw_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .trigger(trigger),
   .scan_out(scan_out), .busy(busy), .done(done), .cut_din(cut_din)
);

// File: tb/sim_atspeed_wrap.sv
`timescale 1ns/1ps
module sim_atspeed_wrap;
   localparam int NPAT = 4;
   localparam int DW   = 8;
   localparam int LAT  = 3;
   localparam int TOT  = NPAT * DW;
   localparam logic [DW-1:0] MASK = 8'h5A;
   localparam int NVEC = 3;
   localparam logic [TOT-1:0] VEC [NVEC] = '{32'h00FF_A53C, 32'h0123_4567, 32'hDEAD_BEEF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slow_en = 1'b0, scan_in = 1'b0, trigger = 1'b0;
   logic scan_out, busy, done;
   logic [DW-1:0] cut_din, cut_dout;
   logic [DW-1:0] dl [LAT];
   int total = 0, bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   atspeed_wrap #(.NPAT(NPAT), .DW(DW), .LATENCY(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .scan_in(scan_in),
      .trigger(trigger), .cut_dout(cut_dout), .scan_out(scan_out),
      .busy(busy), .done(done), .cut_din(cut_din)
   );

   // CUT model: LAT-stage delay line with an XOR mask
   always_ff @(posedge clk) begin
      dl[0] <= cut_din ^ MASK;
      for (int i = 1; i < LAT; i++) dl[i] <= dl[i-1];
   end
   assign cut_dout = dl[LAT-1];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_word(input logic [TOT-1:0] w, input bit trig_mid);
      for (int i = 0; i < TOT; i++) begin
         scan_in = w[TOT-1-i];
         slow_en = 1'b1;
         if (trig_mid && i == TOT/2) trigger = 1'b1;
         @(negedge clk);
         slow_en = 1'b0;
         trigger = 1'b0;
         if (trig_mid && i == TOT/2) chk("R3 trigger mid-load ignored", busy, 0);
         @(negedge clk);
      end
   endtask

   task automatic unload(output logic [TOT-1:0] got);
      bit early = 0;
      for (int i = 0; i < TOT; i++) begin
         slow_en = 1'b1;
         @(negedge clk);
         slow_en = 1'b0;
         got[TOT-1-i] = scan_out;
         if (i < TOT-1 && done) early = 1;
         if (i == TOT-1) begin
            chk("R7 done with last bit", done, 1);
            chk("R7 idle at done", busy, 0);
         end
         @(negedge clk);
         if (i == TOT-1) chk("R7 done one cycle", done, 0);
      end
      chk("R7 no early done", early, 0);
   endtask

   task automatic burst(input logic [TOT-1:0] w, input bit inj_slow, input bit trig_unl);
      logic [TOT-1:0] got, exp;
      @(negedge clk);
      trigger = 1'b1;
      @(negedge clk);
      trigger = 1'b0;
      chk("R8 busy after trigger", busy, 1);
      for (int k = 0; k < NPAT; k++) begin
         chk("R4 vector on cut_din", cut_din, (w >> ((NPAT-1-k)*DW)) & {DW{1'b1}});
         slow_en = (inj_slow && k == 1);
         scan_in = 1'b1;
         @(negedge clk);
         slow_en = 1'b0;
      end
      chk("R4 cut_din zero after burst", cut_din, 0);
      repeat (LAT + 1) @(negedge clk);
      if (trig_unl) begin
         trigger = 1'b1;
         @(negedge clk);
         trigger = 1'b0;
         chk("R3 trigger while busy ignored", cut_din, 0);
      end
      chk("R8 busy before readout", busy, 1);
      unload(got);
      exp = w ^ {NPAT{MASK}};
      chk("R5 R6 result word", got, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 scan_out", scan_out, 0);
      chk("R1 cut_din", cut_din, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: trigger with nothing loaded
      trigger = 1'b1;
      @(negedge clk);
      trigger = 1'b0;
      @(negedge clk);
      chk("R3 trigger before load", busy, 0);

      // table walk: R2 R4 R5 R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         load_word(VEC[v], v == 0);
         burst(VEC[v], v == 1, v == 2);
      end

      // R3: retrigger without a new load
      @(negedge clk);
      trigger = 1'b1;
      @(negedge clk);
      trigger = 1'b0;
      @(negedge clk);
      chk("R3 retrigger without load", busy, 0);
      chk("R3 retrigger cut_din", cut_din, 0);

      // corner: all ones then all zeros
      load_word({TOT{1'b1}}, 0);
      burst({TOT{1'b1}}, 0, 0);
      load_word('0, 0);
      burst('0, 1, 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule